// File: doc/BRIEF.md
# Configurable Wrapping Counter with Look-Ahead

A parameterised binary counter that counts either up or down, one step per enabled clock, and wraps modulo 2^W. Its width, power-up value, reset value, counting direction and a fixed look-ahead distance are parameters. A load input writes an arbitrary value into the counter and wins over counting. A clock-enable input gates every change of state except reset.

Three results leave the block. The current count and a one-cycle wrap flag come straight from the state registers, with no output stage behind them. The look-ahead value is combinational: it is the current count moved the chosen number of steps further in the counting direction. Typical use is a pointer or timer whose consumer needs to know, one or more steps early, where the count is heading.

Top module: `cfg_counter`

## Requirements
- R1: Before the first clock edge the count equals parameter INIT_VAL (truncated to W bits) and the wrap flag is low.
- R2: When `rst` is high at a rising edge the count becomes RST_VAL (truncated to W bits) and the wrap flag goes low, whatever the other inputs are, including with `clk_en` low.
- R3: With `rst` low and `clk_en` low at an edge the count keeps its value and the wrap flag goes low; `load`, `load_val` and `cnt_en` have no effect.
- R4: With `rst` low, `clk_en` high and `load` high at an edge the count becomes `load_val` and the wrap flag goes low, whatever `cnt_en` is.
- R5: With `rst` low, `clk_en` high, `load` low and `cnt_en` high at an edge the count moves one step modulo 2^W: +1 when DIRECTION is DIR_UP, -1 when DIRECTION is DIR_DOWN.
- R6: With `rst` low, `clk_en` high, `load` low and `cnt_en` low at an edge the count keeps its value and the wrap flag goes low.
- R7: The wrap flag is high for the single cycle after a step from all ones to zero (DIR_UP) or from zero to all ones (DIR_DOWN), and low after every other edge.
- R8: `ahead_val` equals the count plus AHEAD (DIR_UP) or minus AHEAD (DIR_DOWN) modulo 2^W in the same cycle, with no clock in between; with AHEAD = 0 it equals the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Gates every state change except reset |
| cnt_en | input | 1 | Requests one counting step |
| load | input | 1 | Writes `load_val`, overrides `cnt_en` |
| load_val | input | W | Value written by a load |
| count | output | W | Current count, straight from the state register |
| ahead_val | output | W | Count moved AHEAD steps in the counting direction |
| wrap_flag | output | 1 | One-cycle pulse after a wrapping step |

## Verification
Count and wrap flag are due exactly one edge after the inputs that cause them, while the look-ahead value follows the count in the same cycle with no edge of its own. The bench therefore drives every input on a falling edge, lets one rising edge pass, and compares all three results on the next falling edge against a model advanced once per edge. The power-up values are compared before any rising edge. Two counters, one per direction and each with its own power-up, reset and look-ahead values, plus a third with zero look-ahead, share the stimulus so every sequence covers both directions.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } cnt_dir_e;

  typedef enum logic [2:0] {
    ACT_RESET = 3'd0,
    ACT_GATED = 3'd1,
    ACT_LOAD  = 3'd2,
    ACT_STEP  = 3'd3,
    ACT_IDLE  = 3'd4
  } cnt_act_e;

  function automatic logic dir_is_down(input cnt_dir_e dir);
    return dir == DIR_DOWN;
  endfunction

endpackage

// File: rtl/cnt_offset_unit.sv
module cnt_offset_unit #(
  parameter int               W         = 4,
  parameter cnt_pkg::cnt_dir_e DIRECTION = cnt_pkg::DIR_UP,
  parameter int               DIST      = 1
) (
  input  logic [W-1:0] base,
  output logic [W-1:0] moved
);
  localparam logic [W-1:0] DIST_W = W'(DIST);

  function automatic logic [W-1:0] move_up(input logic [W-1:0] v);
    return v + DIST_W;
  endfunction

  function automatic logic [W-1:0] move_down(input logic [W-1:0] v);
    return v - DIST_W;
  endfunction

  generate
    if (cnt_pkg::dir_is_down(DIRECTION)) begin : g_down
      assign moved = move_down(base);
    end else begin : g_up
      assign moved = move_up(base);
    end
  endgenerate
endmodule

// File: rtl/cnt_wrap_detect.sv
module cnt_wrap_detect #(
  parameter int               W         = 4,
  parameter cnt_pkg::cnt_dir_e DIRECTION = cnt_pkg::DIR_UP
) (
  input  logic [W-1:0] cur,
  output logic         at_edge
);
  generate
    if (cnt_pkg::dir_is_down(DIRECTION)) begin : g_down
      assign at_edge = (cur == '0);
    end else begin : g_up
      assign at_edge = &cur;
    end
  endgenerate
endmodule

// File: rtl/cnt_ctrl.sv
module cnt_ctrl (
  input  logic              rst,
  input  logic              clk_en,
  input  logic              load,
  input  logic              cnt_en,
  output cnt_pkg::cnt_act_e act
);
  import cnt_pkg::*;

  always_comb begin
    if (rst)          act = ACT_RESET;
    else if (!clk_en) act = ACT_GATED;
    else if (load)    act = ACT_LOAD;
    else if (cnt_en)  act = ACT_STEP;
    else              act = ACT_IDLE;
  end
endmodule

// File: rtl/cfg_counter.sv
module cfg_counter #(
  parameter int               W         = 4,
  parameter int               INIT_VAL  = 0,
  parameter int               RST_VAL   = 0,
  parameter cnt_pkg::cnt_dir_e DIRECTION = cnt_pkg::DIR_UP,
  parameter int               AHEAD     = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clk_en,
  input  logic         cnt_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic [W-1:0] ahead_val,
  output logic         wrap_flag
);
  import cnt_pkg::*;

  localparam logic [W-1:0] INIT_W = W'(INIT_VAL);
  localparam logic [W-1:0] RST_W  = W'(RST_VAL);

  logic [W-1:0] cnt_q = INIT_W;
  logic         wrap_q = 1'b0;

  cnt_act_e     act;
  logic [W-1:0] stepped;
  logic         at_edge;

  // named events, visible to the bound checker
  logic evt_load;
  logic evt_step;
  logic evt_wrap;

  cnt_ctrl ctrl_i (
    .rst   (rst),
    .clk_en(clk_en),
    .load  (load),
    .cnt_en(cnt_en),
    .act   (act)
  );

  cnt_offset_unit #(.W(W), .DIRECTION(DIRECTION), .DIST(1)) step_i (
    .base (cnt_q),
    .moved(stepped)
  );

  cnt_offset_unit #(.W(W), .DIRECTION(DIRECTION), .DIST(AHEAD)) ahead_i (
    .base (cnt_q),
    .moved(ahead_val)
  );

  cnt_wrap_detect #(.W(W), .DIRECTION(DIRECTION)) edge_i (
    .cur    (cnt_q),
    .at_edge(at_edge)
  );

  assign evt_load = (act == ACT_LOAD);
  assign evt_step = (act == ACT_STEP);
  assign evt_wrap = evt_step && at_edge;

  always_ff @(posedge clk) begin
    unique case (act)
      ACT_RESET: cnt_q <= RST_W;
      ACT_LOAD:  cnt_q <= load_val;
      ACT_STEP:  cnt_q <= stepped;
      default:   cnt_q <= cnt_q;
    endcase
    wrap_q <= evt_wrap;
  end

  assign count     = cnt_q;
  assign wrap_flag = wrap_q;
endmodule

// File: rtl/cfg_counter_chk.sv
module cfg_counter_chk #(
  parameter int               W         = 4,
  parameter int               RST_VAL   = 0,
  parameter cnt_pkg::cnt_dir_e DIRECTION = cnt_pkg::DIR_UP,
  parameter int               AHEAD     = 0
) (
  input logic         clk,
  input logic         rst,
  input logic         clk_en,
  input logic         cnt_en,
  input logic         load,
  input logic [W-1:0] load_val,
  input logic [W-1:0] count,
  input logic [W-1:0] ahead_val,
  input logic         wrap_flag,
  input logic         evt_load,
  input logic         evt_step
);
  localparam bit           DOWN  = cnt_pkg::dir_is_down(DIRECTION);
  localparam logic [W-1:0] STEP  = DOWN ? '1 : W'(1);
  localparam logic [W-1:0] EDGEV = DOWN ? '0 : '1;
  localparam logic [W-1:0] OFS   = DOWN ? W'(0 - AHEAD) : W'(AHEAD);

  // R2
  reset_load_chk: assert property (@(posedge clk)
    rst |=> (count == W'(RST_VAL)) && !wrap_flag);

  // R3
  gated_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> $stable(count) && !wrap_flag);

  // R4
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    evt_load |=> (count == $past(load_val)) && !wrap_flag);

  // R5
  step_move_chk: assert property (@(posedge clk) disable iff (rst)
    evt_step |=> count == W'($past(count) + STEP));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !load && !cnt_en) |=> $stable(count) && !wrap_flag);

  // R7
  wrap_set_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_step && count == EDGEV) |=> wrap_flag);

  // R7
  wrap_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !(clk_en && !load && cnt_en && count == EDGEV) |=> !wrap_flag);

  // R8
  ahead_off_chk: assert property (@(posedge clk)
    W'(ahead_val - count) == OFS);
endmodule

bind cfg_counter cfg_counter_chk #(
  .W(W), .RST_VAL(RST_VAL), .DIRECTION(DIRECTION), .AHEAD(AHEAD)
) chk_i (
  .clk(clk), .rst(rst), .clk_en(clk_en), .cnt_en(cnt_en), .load(load),
  .load_val(load_val), .count(count), .ahead_val(ahead_val),
  .wrap_flag(wrap_flag), .evt_load(evt_load), .evt_step(evt_step)
);

// File: tb/cfg_counter_tb_top.sv
module cfg_counter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b0, clk_en = 1'b0, cnt_en = 1'b0, load = 1'b0;
  logic [3:0] load_val = '0;
  logic [3:0] cnt_up, ahd_up, cnt_dn, ahd_dn, cnt_z, ahd_z;
  logic       wf_up, wf_dn, wf_z;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // model state
  int m_up = 5, m_dn = 2, m_z = 0;
  bit f_up = 0, f_dn = 0, f_z = 0;

  always #10 clk = ~clk;

  cfg_counter #(.W(4), .INIT_VAL(5), .RST_VAL(9),
                .DIRECTION(cnt_pkg::DIR_UP), .AHEAD(3)) dut_i (
    .clk(clk), .rst(rst), .clk_en(clk_en), .cnt_en(cnt_en), .load(load),
    .load_val(load_val), .count(cnt_up), .ahead_val(ahd_up), .wrap_flag(wf_up));

  cfg_counter #(.W(4), .INIT_VAL(2), .RST_VAL(1),
                .DIRECTION(cnt_pkg::DIR_DOWN), .AHEAD(2)) dut_dn_i (
    .clk(clk), .rst(rst), .clk_en(clk_en), .cnt_en(cnt_en), .load(load),
    .load_val(load_val), .count(cnt_dn), .ahead_val(ahd_dn), .wrap_flag(wf_dn));

  cfg_counter #(.W(4)) dut_z_i (
    .clk(clk), .rst(rst), .clk_en(clk_en), .cnt_en(cnt_en), .load(load),
    .load_val(load_val), .count(cnt_z), .ahead_val(ahd_z), .wrap_flag(wf_z));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "up count", int'(cnt_up), m_up);
    chk(req, "down count", int'(cnt_dn), m_dn);
    chk(req, "zero-ahead count", int'(cnt_z), m_z);
    chk("R7", "up wrap flag", int'(wf_up), int'(f_up));
    chk("R7", "down wrap flag", int'(wf_dn), int'(f_dn));
    chk("R7", "zero-ahead wrap flag", int'(wf_z), int'(f_z));
    chk("R8", "up ahead", int'(ahd_up), (m_up + 3) % 16);
    chk("R8", "down ahead", int'(ahd_dn), (m_dn + 14) % 16);
    chk("R8", "zero ahead", int'(ahd_z), m_z);
  endtask

  // drive at falling edge, one rising edge, compare at next falling edge
  task automatic cycle(input bit r, input bit ce, input bit en, input bit ld,
                       input int val, input string req);
    rst = r; clk_en = ce; cnt_en = en; load = ld; load_val = 4'(val);
    @(posedge clk);
    @(negedge clk);
    f_up = 0; f_dn = 0; f_z = 0;
    if (r) begin
      m_up = 9; m_dn = 1; m_z = 0;
    end else if (ce && ld) begin
      m_up = val % 16; m_dn = val % 16; m_z = val % 16;
    end else if (ce && en) begin
      f_up = (m_up == 15); f_z = (m_z == 15); f_dn = (m_dn == 0);
      m_up = (m_up + 1) % 16; m_z = (m_z + 1) % 16; m_dn = (m_dn + 15) % 16;
    end
    check_all(req);
  endtask

  task automatic t_powerup;
    #1;
    check_all("R1");
  endtask

  task automatic t_reset_gated;
    cycle(1, 0, 1, 1, 7, "R2");
  endtask

  task automatic t_gate_blocks;
    cycle(0, 0, 1, 1, 7, "R3");
    cycle(0, 0, 1, 0, 0, "R3");
  endtask

  task automatic t_load_priority;
    cycle(0, 1, 1, 1, 14, "R4");
    cycle(0, 1, 0, 1, 3, "R4");
  endtask

  task automatic t_count_run;
    cycle(0, 1, 0, 1, 13, "R4");
    for (int i = 0; i < 20; i++) cycle(0, 1, 1, 0, 0, "R5");
  endtask

  task automatic t_idle;
    cycle(0, 1, 0, 0, 0, "R6");
    cycle(0, 1, 0, 0, 5, "R6");
  endtask

  task automatic t_wrap_then_load;
    cycle(0, 1, 0, 1, 15, "R4");
    cycle(0, 1, 1, 0, 0, "R7");
    cycle(0, 1, 1, 1, 0, "R4");
    cycle(0, 1, 1, 0, 0, "R7");
  endtask

  task automatic t_wrap_then_gate;
    cycle(0, 1, 0, 1, 15, "R4");
    cycle(0, 1, 1, 0, 0, "R7");
    cycle(0, 0, 1, 0, 0, "R3");
  endtask

  task automatic t_reset_wins;
    cycle(0, 1, 1, 0, 0, "R5");
    cycle(1, 1, 1, 1, 6, "R2");
    cycle(0, 1, 1, 0, 0, "R5");
  endtask

  initial begin
    t_powerup();
    @(negedge clk);
    t_reset_gated();
    t_gate_blocks();
    t_load_priority();
    t_count_run();
    t_idle();
    t_wrap_then_load();
    t_wrap_then_gate();
    t_reset_wins();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4ms;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule